// File: doc/BRIEF.md
# Kernel Streaming Sequencer with Clock Crossing

This block sits between a host bus and an arithmetic accelerator. From the host side the block receives three things before a run. The first is a short kernel of instructions. The second is a table of 128-bit data records, one or more words per record. The third is three configuration values. Each kind of content is held in its own dual-port RAM. One write port of each RAM runs on the host clock and the read port runs on the accelerator clock. When the host gives a start pulse, the accelerator-side state machine takes each stored record in turn. It sends the words of that record into the accelerator's input broadcast memory over a 64-bit link, with the low half of each word first and the high half second. It then replays the whole kernel, one instruction per beat. After the last record it returns a completion event to the host.

Results that the accelerator pushes back are written into an asynchronous FIFO. The host later pops them in its own clock domain. The start and done events each cross the clock boundary by toggle handshake. Configuration values are only written while no run is in progress, so they are stable whenever the accelerator side uses them.

The sequencer states are IDLE, DFETCH, DLO, DHI, IFETCH, IEMIT and FINISH. The transitions are:
- IDLE→DFETCH on a start event with a nonzero record count.
- IDLE→FINISH on a start event with a record count of zero.
- DFETCH→DLO→DHI, always.
- DHI→DFETCH when more words remain in the record.
- DHI→IFETCH after the last word of a record.
- IFETCH→IEMIT, always.
- IEMIT→IFETCH when more instructions remain.
- IEMIT→DFETCH after the last instruction, when records remain.
- IEMIT→FINISH after the last instruction of the last record.
- FINISH→IDLE, always.

Top module: `kstream_seq`

## Requirements
- R1: After reset: no link beat or instruction is issued, the result FIFO is empty and not full, and busy, done and cfg_err are all 0.
- R2: Writing a record count above 1984 stores 1984 and sets cfg_err. Writing a record count of 1984 or less stores it unchanged and clears cfg_err.
- R3: Every word of a record is sent as two consecutive beats. The first beat has bm_wr_half=0 and carries bits 63:0. The second beat has bm_wr_half=1 and carries bits 127:64. bm_wr_index is the word's position within its record, starting at 0.
- R4: After the last word of a record, the kernel instructions 0 to L-1 are issued in order, one per inst_valid beat.
- R5: Records are streamed in order, and record r uses stored data words r·W to r·W+W-1. After the last record, busy falls and done rises, and no further beat follows.
- R6: While busy, a start pulse or a configuration write has no effect.
- R7: A run with a record count of 0 raises done without issuing any beat.
- R8: Results pushed while res_full is low are popped by the host in the same order, with res_data showing the oldest entry. A push while res_full is high is dropped. res_full rises once 16 entries are stored.
- R9: A data beat and an instruction beat are never issued in the same accelerator cycle.
- R10: Configuration addresses are fixed. Address 0 holds the record count in data bits 15:0. Address 1 holds the words per record minus one in bits 2:0. Address 2 holds the kernel length minus one in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-side clock |
| host_rst_n | input | 1 | Host-side asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_err | output | 1 | Record count was clamped |
| imem_we | input | 1 | Kernel store write strobe |
| imem_addr | input | 6 | Kernel store address |
| imem_wdata | input | 64 | Instruction to store |
| dmem_we | input | 1 | Record store write strobe |
| dmem_addr | input | 11 | Record store word address |
| dmem_wdata | input | 128 | Data word to store |
| start | input | 1 | Run request pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has completed |
| res_pop | input | 1 | Pop the oldest result |
| res_data | output | 128 | Oldest result (show-ahead) |
| res_empty | output | 1 | Result FIFO empty |
| acc_clk | input | 1 | Accelerator-side clock |
| acc_rst_n | input | 1 | Accelerator-side asynchronous reset, active low |
| bm_wr_valid | output | 1 | Data beat valid |
| bm_wr_index | output | 3 | Word index within the record |
| bm_wr_half | output | 1 | 0 = low half, 1 = high half |
| bm_wr_data | output | 64 | Beat payload |
| inst_valid | output | 1 | Instruction beat valid |
| inst_data | output | 64 | Instruction payload |
| res_push | input | 1 | Result write strobe from the accelerator |
| res_push_data | input | 128 | Result word |
| res_full | output | 1 | Result FIFO full |

## Verification
In the accelerator domain, the sequencer can emit a link beat in the same cycle that the accelerator pushes a result into the FIFO. The bench provokes this by driving a train of result pushes in parallel with a run. The beat stream is then compared against an expected queue, and the results are later popped and compared in order, so a collision that corrupts either stream is caught. A second overlap puts a start pulse or a configuration write in a cycle where a run is still in progress. The bench judges this by the exact length and content of the beat stream and by a following run that must reuse the old configuration.

// File: rtl/ks_pkg.sv
package ks_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DFETCH,
        ST_DLO,
        ST_DHI,
        ST_IFETCH,
        ST_IEMIT,
        ST_FINISH
    } ks_state_e;
endpackage

// File: rtl/ks_dpram.sv
module ks_dpram #(
    parameter int W = 128,
    parameter int D = 2048
) (
    input  logic                 wclk,
    input  logic                 we,
    input  logic [$clog2(D)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic                 rclk,
    input  logic [$clog2(D)-1:0] raddr,
    output logic [W-1:0]         rdata
);
    logic [W-1:0] mem [D];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ks_pulse_sync.sv
module ks_pulse_sync (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog;
    logic [2:0] sync;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) tog <= 1'b0;
        else            tog <= tog ^ src_pulse;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) sync <= '0;
        else            sync <= {sync[1:0], tog};
    end

    assign dst_pulse = sync[2] ^ sync[1];
endmodule

// File: rtl/ks_async_fifo.sv
module ks_async_fifo #(
    parameter int W  = 128,
    parameter int AW = 4
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] rq1, rq2, wq1, wq2;
    logic [AW:0] wbin_nx, rbin_nx;
    logic        do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign wbin_nx = wbin + {{AW{1'b0}}, do_push};
    assign rbin_nx = rbin + {{AW{1'b0}}, do_pop};

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= (wbin_nx >> 1) ^ wbin_nx;
        end
    end

    always_ff @(posedge wclk) begin
        if (do_push) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) {rq2, rq1} <= '0;
        else         {rq2, rq1} <= {rq1, rgray};
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= (rbin_nx >> 1) ^ rbin_nx;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) {wq2, wq1} <= '0;
        else         {wq2, wq1} <= {wq1, wgray};
    end

    assign full  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign empty = (rgray == wq2);
    assign rdata = mem[rbin[AW-1:0]];

    p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
        (push && full) |=> $stable(wgray));
    p_no_underflow_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
        (pop && empty) |=> $stable(rgray));
    p_gray_step_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
        $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/ks_stream_fsm.sv
module ks_stream_fsm
    import ks_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int INSTR_W = 64,
    parameter int DAW     = 11,
    parameter int IAW     = 6,
    parameter int WIW     = 3,
    parameter int RCW     = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [RCW-1:0]      nrec,
    input  logic [WIW-1:0]      wpr_m1,
    input  logic [IAW-1:0]      klen_m1,
    output logic [DAW-1:0]      daddr,
    input  logic [DATA_W-1:0]   dq,
    output logic [IAW-1:0]      iaddr,
    input  logic [INSTR_W-1:0]  iq,
    output logic                bm_wr_valid,
    output logic [WIW-1:0]      bm_wr_index,
    output logic                bm_wr_half,
    output logic [DATA_W/2-1:0] bm_wr_data,
    output logic                inst_valid,
    output logic [INSTR_W-1:0]  inst_data,
    output logic                fin
);
    localparam int LINK_W = DATA_W / 2;

    ks_state_e state_q, state_d;
    logic [RCW-1:0] rec_q;
    logic [WIW-1:0] word_q;
    logic [IAW-1:0] ip_q;
    logic [DAW-1:0] dptr_q;
    logic last_word, last_instr, last_rec;

    assign last_word  = (word_q == wpr_m1);
    assign last_instr = (ip_q == klen_m1);
    assign last_rec   = ((rec_q + RCW'(1)) == nrec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = (nrec == '0) ? ST_FINISH : ST_DFETCH;
            ST_DFETCH: state_d = ST_DLO;
            ST_DLO:    state_d = ST_DHI;
            ST_DHI:    state_d = last_word ? ST_IFETCH : ST_DFETCH;
            ST_IFETCH: state_d = ST_IEMIT;
            ST_IEMIT: begin
                if (!last_instr)   state_d = ST_IFETCH;
                else if (last_rec) state_d = ST_FINISH;
                else               state_d = ST_DFETCH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q  <= '0;
            word_q <= '0;
            ip_q   <= '0;
            dptr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rec_q  <= '0;
                    word_q <= '0;
                    ip_q   <= '0;
                    dptr_q <= '0;
                end
                ST_DHI: begin
                    word_q <= last_word ? '0 : word_q + WIW'(1);
                    dptr_q <= dptr_q + DAW'(1);
                end
                ST_IEMIT: begin
                    ip_q <= last_instr ? '0 : ip_q + IAW'(1);
                    if (last_instr) rec_q <= rec_q + RCW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        daddr       = dptr_q;
        iaddr       = ip_q;
        bm_wr_valid = (state_q == ST_DLO) || (state_q == ST_DHI);
        bm_wr_half  = (state_q == ST_DHI);
        bm_wr_index = word_q;
        bm_wr_data  = bm_wr_half ? dq[DATA_W-1:LINK_W] : dq[LINK_W-1:0];
        inst_valid  = (state_q == ST_IEMIT);
        inst_data   = iq;
        fin         = (state_q == ST_FINISH);
    end

    p_link_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_wr_valid && inst_valid));
    p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_wr_valid && !bm_wr_half) |=> (bm_wr_valid && bm_wr_half && $stable(bm_wr_index)));
endmodule

// File: rtl/kstream_seq.sv
module kstream_seq #(
    parameter int DATA_W     = 128,
    parameter int INSTR_W    = 64,
    parameter int MAX_REC    = 1984,
    parameter int DATA_DEPTH = 2048,
    parameter int KMAX       = 64,
    parameter int WMAX       = 8,
    parameter int FIFO_AW    = 4
) (
    input  logic                       host_clk,
    input  logic                       host_rst_n,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_addr,
    input  logic [15:0]                cfg_wdata,
    output logic                       cfg_err,
    input  logic                       imem_we,
    input  logic [$clog2(KMAX)-1:0]    imem_addr,
    input  logic [INSTR_W-1:0]         imem_wdata,
    input  logic                       dmem_we,
    input  logic [$clog2(DATA_DEPTH)-1:0] dmem_addr,
    input  logic [DATA_W-1:0]          dmem_wdata,
    input  logic                       start,
    output logic                       busy,
    output logic                       done,
    input  logic                       res_pop,
    output logic [DATA_W-1:0]          res_data,
    output logic                       res_empty,
    input  logic                       acc_clk,
    input  logic                       acc_rst_n,
    output logic                       bm_wr_valid,
    output logic [$clog2(WMAX)-1:0]    bm_wr_index,
    output logic                       bm_wr_half,
    output logic [DATA_W/2-1:0]        bm_wr_data,
    output logic                       inst_valid,
    output logic [INSTR_W-1:0]         inst_data,
    input  logic                       res_push,
    input  logic [DATA_W-1:0]          res_push_data,
    output logic                       res_full
);
    localparam int DAW = $clog2(DATA_DEPTH);
    localparam int IAW = $clog2(KMAX);
    localparam int WIW = $clog2(WMAX);
    localparam int RCW = $clog2(MAX_REC + 1);

    logic [RCW-1:0] rec_cnt;
    logic [WIW-1:0] wpr_m1;
    logic [IAW-1:0] klen_m1;
    logic           start_ok, go_acc, fin_acc, fin_host;
    logic [DAW-1:0] daddr;
    logic [IAW-1:0] iaddr;
    logic [DATA_W-1:0]  dq;
    logic [INSTR_W-1:0] iq;

    assign start_ok = start && !busy;

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            rec_cnt <= '0;
            wpr_m1  <= '0;
            klen_m1 <= '0;
            cfg_err <= 1'b0;
        end else if (cfg_we && !busy) begin
            unique case (cfg_addr)
                2'd0: begin
                    if (int'(cfg_wdata) > MAX_REC) begin
                        rec_cnt <= RCW'(MAX_REC);
                        cfg_err <= 1'b1;
                    end else begin
                        rec_cnt <= cfg_wdata[RCW-1:0];
                        cfg_err <= 1'b0;
                    end
                end
                2'd1:    wpr_m1  <= cfg_wdata[WIW-1:0];
                2'd2:    klen_m1 <= cfg_wdata[IAW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start_ok) begin
            busy <= 1'b1;
            done <= 1'b0;
        end else if (fin_host) begin
            busy <= 1'b0;
            done <= 1'b1;
        end
    end

    ks_pulse_sync i_start_sync (
        .src_clk(host_clk), .src_rst_n(host_rst_n), .src_pulse(start_ok),
        .dst_clk(acc_clk),  .dst_rst_n(acc_rst_n),  .dst_pulse(go_acc)
    );

    ks_pulse_sync i_done_sync (
        .src_clk(acc_clk),  .src_rst_n(acc_rst_n),  .src_pulse(fin_acc),
        .dst_clk(host_clk), .dst_rst_n(host_rst_n), .dst_pulse(fin_host)
    );

    ks_dpram #(.W(INSTR_W), .D(KMAX)) i_kernel_ram (
        .wclk(host_clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
        .rclk(acc_clk),  .raddr(iaddr), .rdata(iq)
    );

    ks_dpram #(.W(DATA_W), .D(DATA_DEPTH)) i_record_ram (
        .wclk(host_clk), .we(dmem_we), .waddr(dmem_addr), .wdata(dmem_wdata),
        .rclk(acc_clk),  .raddr(daddr), .rdata(dq)
    );

    ks_stream_fsm #(
        .DATA_W(DATA_W), .INSTR_W(INSTR_W), .DAW(DAW),
        .IAW(IAW), .WIW(WIW), .RCW(RCW)
    ) i_fsm (
        .clk(acc_clk), .rst_n(acc_rst_n), .go(go_acc),
        .nrec(rec_cnt), .wpr_m1(wpr_m1), .klen_m1(klen_m1),
        .daddr(daddr), .dq(dq), .iaddr(iaddr), .iq(iq),
        .bm_wr_valid(bm_wr_valid), .bm_wr_index(bm_wr_index),
        .bm_wr_half(bm_wr_half), .bm_wr_data(bm_wr_data),
        .inst_valid(inst_valid), .inst_data(inst_data), .fin(fin_acc)
    );

    ks_async_fifo #(.W(DATA_W), .AW(FIFO_AW)) i_result_fifo (
        .wclk(acc_clk),   .wrst_n(acc_rst_n),  .push(res_push), .wdata(res_push_data),
        .full(res_full),
        .rclk(host_clk),  .rrst_n(host_rst_n), .pop(res_pop),   .rdata(res_data),
        .empty(res_empty)
    );

    p_busy_cfg_r6: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (busy && cfg_we) |=> ($stable(rec_cnt) && $stable(wpr_m1) && $stable(klen_m1)));
    p_clamp_r2: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (cfg_we && !busy && cfg_addr == 2'd0) |=> (int'(rec_cnt) <= MAX_REC));
    p_start_busy_r6: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (start && busy) |=> busy);
endmodule

// File: tb/test_kstream_seq.sv
module test_kstream_seq;
    logic host_clk = 1'b0, acc_clk = 1'b0;
    logic host_rst_n = 1'b0, acc_rst_n = 1'b0;
    logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [15:0] cfg_wdata = 0;
    logic cfg_err;
    logic imem_we = 0; logic [5:0] imem_addr = 0; logic [63:0] imem_wdata = 0;
    logic dmem_we = 0; logic [10:0] dmem_addr = 0; logic [127:0] dmem_wdata = 0;
    logic start = 0, busy, done;
    logic res_pop = 0; logic [127:0] res_data; logic res_empty;
    logic bm_wr_valid; logic [2:0] bm_wr_index; logic bm_wr_half; logic [63:0] bm_wr_data;
    logic inst_valid; logic [63:0] inst_data;
    logic res_push = 0; logic [127:0] res_push_data = 0; logic res_full;

    int checks = 0, errors = 0;
    logic [68:0]  exp_beats[$];
    logic [127:0] exp_res[$];
    int kgen = 0;

    always #5 acc_clk  = ~acc_clk;
    always #4 host_clk = ~host_clk;

    kstream_seq i_kstream_seq (.*);

    function automatic logic [127:0] dval(int i);
        return {32'hA5A5_0000 ^ i, 32'h1111_0000 + i, i * 3, ~i};
    endfunction

    function automatic logic [63:0] ival(int k, int g);
        return 64'hC0DE_0000_0000_0000 + 64'(k) + 64'(g * 256);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Beat monitor: every accelerator clock, compared with the expected queue.
    always @(negedge acc_clk) begin
        if (acc_rst_n) begin
            if (bm_wr_valid && inst_valid)
                chk(0, "R9 data and instruction beat together", 128'(inst_data), 128'(bm_wr_data));
            if (bm_wr_valid || inst_valid) begin
                logic [68:0] act;
                act = inst_valid ? {1'b1, 3'd0, 1'b0, inst_data}
                                 : {1'b0, bm_wr_index, bm_wr_half, bm_wr_data};
                if (exp_beats.size() == 0)
                    chk(0, "R5 unexpected beat", 128'(act), 128'(0));
                else begin
                    logic [68:0] e;
                    e = exp_beats.pop_front();
                    chk(act == e, e[68] ? "R4 instruction beat" : "R3 data beat", 128'(act), 128'(e));
                end
            end
        end
    end

    task automatic host_cfg(input int a, input int v);
        @(negedge host_clk); cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 16'(v);
        @(negedge host_clk); cfg_we = 0;
    endtask

    task automatic load_kernel(input int len);
        kgen++;
        for (int k = 0; k < len; k++) begin
            @(negedge host_clk); imem_we = 1; imem_addr = 6'(k); imem_wdata = ival(k, kgen);
        end
        @(negedge host_clk); imem_we = 0;
    endtask

    task automatic expect_run(input int nrec, input int wpr, input int klen);
        for (int r = 0; r < nrec; r++) begin
            for (int w = 0; w < wpr; w++) begin
                logic [127:0] d;
                d = dval((r * wpr + w) % 2048);
                exp_beats.push_back({1'b0, 3'(w), 1'b0, d[63:0]});
                exp_beats.push_back({1'b0, 3'(w), 1'b1, d[127:64]});
            end
            for (int k = 0; k < klen; k++)
                exp_beats.push_back({1'b1, 3'd0, 1'b0, ival(k, kgen)});
        end
    endtask

    task automatic pulse_start();
        @(negedge host_clk); start = 1;
        @(negedge host_clk); start = 0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while ((busy || !done) && n < 40000) begin
            @(negedge host_clk); n++;
        end
        repeat (20) @(negedge acc_clk);
        chk(!busy && done, req, {busy, done}, 2'b01);
        chk(exp_beats.size() == 0, req, exp_beats.size(), 0);
    endtask

    task automatic run(input int nrec, input int wpr, input int klen, input string req);
        expect_run(nrec, wpr, klen);
        pulse_start();
        wait_done(req);
    endtask

    task automatic push_results(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge acc_clk);
            res_push = 1; res_push_data = {32'hBEEF_0000 + base + i, 96'(i)};
            if (!res_full) exp_res.push_back(res_push_data);
        end
        @(negedge acc_clk); res_push = 0;
    endtask

    task automatic drain();
        int n = 0;
        repeat (6) @(negedge host_clk);
        while (!res_empty && n < 200) begin
            logic [127:0] e;
            e = (exp_res.size() > 0) ? exp_res.pop_front() : 128'hX;
            chk(res_data === e, "R8 result order", res_data, e);
            res_pop = 1; @(negedge host_clk); res_pop = 0; n++;
        end
        chk(exp_res.size() == 0 && res_empty, "R8 drained", exp_res.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge acc_clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge acc_clk);
        host_rst_n = 1; acc_rst_n = 1;
        repeat (2) @(negedge host_clk);
        // R1 reset state
        chk(!bm_wr_valid && !inst_valid, "R1 link idle", {bm_wr_valid, inst_valid}, 0);
        chk(res_empty && !res_full, "R1 fifo", {res_empty, res_full}, 2'b10);
        chk(!busy && !done && !cfg_err, "R1 status", {busy, done, cfg_err}, 0);

        for (int i = 0; i < 2048; i++) begin
            @(negedge host_clk); dmem_we = 1; dmem_addr = 11'(i); dmem_wdata = dval(i);
        end
        @(negedge host_clk); dmem_we = 0;

        // R10 encodings, R3/R4/R5 with concurrent result pushes (R8)
        load_kernel(4);
        host_cfg(0, 3); host_cfg(1, 1); host_cfg(2, 3);
        chk(!cfg_err, "R2 in-range count", cfg_err, 0);
        expect_run(3, 2, 4);
        pulse_start();
        push_results(5, 0);
        wait_done("R5 three records");
        drain();

        // R3 eight words, R4 single instruction (R10)
        load_kernel(1);
        host_cfg(0, 2); host_cfg(1, 7); host_cfg(2, 0);
        run(2, 8, 1, "R10 eight words one instr");

        // R7 zero records
        host_cfg(0, 0);
        run(0, 1, 1, "R7 zero records");

        // R6 start and config while busy are ignored
        load_kernel(2);
        host_cfg(0, 4); host_cfg(1, 0); host_cfg(2, 1);
        expect_run(4, 1, 2);
        pulse_start();
        repeat (3) @(negedge host_clk);
        pulse_start();
        host_cfg(0, 1);
        host_cfg(2, 5);
        wait_done("R6 single pass");
        run(4, 1, 2, "R6 old config kept");

        // R2 clamp to 1984
        host_cfg(0, 5000);
        chk(cfg_err, "R2 clamp flag", cfg_err, 1);
        host_cfg(2, 0);
        load_kernel(1);
        run(1984, 1, 1, "R2 clamped run");
        host_cfg(0, 10);
        chk(!cfg_err, "R2 flag cleared", cfg_err, 0);

        // R8 full: 20 pushes, 16 kept
        push_results(20, 100);
        chk(res_full, "R8 full flag", res_full, 1);
        chk(exp_res.size() == 16, "R8 kept count", exp_res.size(), 16);
        drain();
        repeat (6) @(negedge acc_clk);
        chk(!res_full, "R8 full clears", res_full, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule